// File: doc/BRIEF.md
# Masked Four-Channel Conversion Sequencer with Threshold Alarms

The block walks a set of analog channels through an external converter in response to a convert request. The request carries a channel select mask and a preset byte. In the cycle the request is accepted, the result register of each selected channel can be forced to all ones or all zeros. The block then issues one conversion per selected channel, lowest channel first, through a simple start/done interface. The converter returns a right-justified raw value. The block shifts that value so its MSB sits at bit 15, stores it, and updates that channel's high and low alarm flags against two 8-bit thresholds.

Configuration lives in a small byte-wide register map. Each channel has a control byte (resolution code and two alarm enables), a flag byte and two thresholds. One extra location holds a power-on indicator bit. The block drives a `ready` level that a status poll reads: it is 0 while a scan runs and 1 once the scan has ended. It also drives a search-participation output, which is high when any enabled alarm flag is set or when the power-on bit is 1.

Top module: `adc_scan_seq`

## Requirements
- R1: Selected channels (mask bit 1) are converted strictly in ascending channel order. Unselected channels are skipped. Each conversion begins with a single-cycle `conv_start` pulse that carries the channel number on `conv_ch`.
- R2: `conv_bits` gives the bit count of the channel being converted. A 4-bit resolution code of 1 to 15 means that many bits, and code 0 means 16 bits.
- R3: The cycle after `conv_done`, the channel's 16-bit result holds the raw value shifted left by (16 − bits), with the bits below the resolution at zero. Result channel c occupies `results[16c+15:16c]`.
- R4: The cycle after a request is accepted, each selected channel's result reflects its 2-bit preset field `req_preset[2c+1:2c]`. The code 01 gives all zeros, 10 gives all ones, and 00 or 11 leaves the result unchanged. Unselected channels are never changed by the preset.
- R5: With 8 or more bits, a conversion sets the high flag when result bits 15:8 exceed the high threshold and the low flag when they are below the low threshold.
- R6: With fewer than 8 bits, the threshold bits below the resolution are treated as zero in both comparisons.
- R7: Each conversion rewrites both flags of its channel, so a non-alarming value clears them. Writing the flag byte ANDs the flags with data bit 0 (low) and bit 1 (high): a 0 clears the flag and a 1 keeps it.
- R8: `search_hit` is 1 exactly when the power-on bit is 1, or when some channel has its low flag and low enable both set, or its high flag and high enable both set.
- R9: After reset, every result is 0, every low threshold is 00h, every high threshold is FFh, every control byte reads 38h (8 bits, both enables on), the flags are 0 and the power-on bit is 1.
- R10: `ready` falls the cycle after a request with a non-zero mask is accepted and rises the cycle after the last selected channel's `conv_done`. A request with an all-zero mask, or any request that arrives while a scan is running, has no effect.
- R11: Register map. Address bit 4 set selects the power-on bit (data bit 0). Otherwise address bits 3:2 give the channel and bits 1:0 select the byte: 0 is control {aeh[5], ael[4], code[3:0]}, 1 is flags {high[1], low[0]}, 2 is the low threshold and 3 is the high threshold. Reads return the same layout, with unused bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Convert request strobe |
| req_mask | input | 4 | Channel select mask |
| req_preset | input | 8 | Two-bit preset code per channel |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 5 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| conv_start | output | 1 | Converter start pulse |
| conv_ch | output | 2 | Channel being converted |
| conv_bits | output | 5 | Bit count requested (1 to 16) |
| conv_done | input | 1 | Converter completion pulse |
| conv_raw | input | 16 | Right-justified raw converter value |
| results | output | 64 | Four 16-bit MSB-aligned results |
| ready | output | 1 | High when no scan is running |
| search_hit | output | 1 | Search participation request |

## Verification
The pending-channel set is internal, but any error in it shows up at the ports. A channel can be skipped or repeated, or `ready` can rise early or late, and either appears at the very next `conv_start` or on `ready` itself within one cycle. The reference model checks `conv_ch`, `conv_bits`, `ready`, all four results and `search_hit` on every clock. A wrong shift or threshold mask therefore shows in the result or in the flag-driven search output one cycle after `conv_done`. Preset errors show one cycle after the request, including any change to a channel that was not selected.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int RW  = $clog2(DW),
  localparam int AW  = CHW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NCH-1:0]    req_mask,
  input  logic [2*NCH-1:0]  req_preset,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_waddr,
  input  logic [7:0]        reg_wdata,
  input  logic [AW-1:0]     reg_raddr,
  output logic [7:0]        reg_rdata,
  output logic              conv_start,
  output logic [CHW-1:0]    conv_ch,
  output logic [RW:0]       conv_bits,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_raw,
  output logic [NCH*DW-1:0] results,
  output logic              ready,
  output logic              search_hit
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [NCH-1:0] pend, pend_rest;
  logic [CHW-1:0] cur;
  logic [DW-1:0]  res_w [NCH];
  logic [RW-1:0]  code_w [NCH];
  logic [7:0]     lo_w [NCH], hi_w [NCH];
  logic [NCH-1:0] ael_w, aeh_w, afl_w, afh_w;
  logic           por;

  logic [RW:0]    nbits;
  logic [DW-1:0]  aligned;
  logic [7:0]     top, tmask;
  logic           accept, finish;

  logic           w_por;
  logic [CHW-1:0] w_ch;
  logic [1:0]     w_sel;

  always_comb begin
    cur = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) cur = CHW'(i);
  end

  assign pend_rest = pend & ~(NCH'(1) << cur);
  assign nbits     = (code_w[cur] == '0) ? (RW+1)'(DW) : {1'b0, code_w[cur]};
  assign aligned   = conv_raw << ((RW+1)'(DW) - nbits);
  assign top       = aligned[DW-1 -: 8];
  assign tmask     = (nbits >= (RW+1)'(8)) ? 8'hFF : 8'(8'hFF << (4'd8 - nbits[3:0]));
  assign accept    = (st == S_IDLE) && req_valid && (req_mask != '0);
  assign finish    = (st == S_WAIT) && conv_done;

  assign w_por = reg_waddr[AW-1];
  assign w_ch  = reg_waddr[CHW+1:2];
  assign w_sel = reg_waddr[1:0];

  assign conv_start = (st == S_ISSUE);
  assign conv_ch    = cur;
  assign conv_bits  = nbits;
  assign ready      = (st == S_IDLE);
  assign search_hit = por | |(afl_w & ael_w) | |(afh_w & aeh_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pend <= '0;
    end else begin
      case (st)
        S_IDLE:  if (accept) begin pend <= req_mask; st <= S_ISSUE; end
        S_ISSUE: st <= S_WAIT;
        S_WAIT:  if (conv_done) begin
                   pend <= pend_rest;
                   st   <= (pend_rest != '0) ? S_ISSUE : S_IDLE;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) por <= 1'b1;
    else if (reg_we && w_por) por <= reg_wdata[0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] res;
    logic [RW-1:0] code;
    logic [7:0]    lo, hi;
    logic          ael, aeh, afl, afh;
    logic [1:0]    pre;
    logic          hit;

    assign pre = req_preset[2*c +: 2];
    assign hit = finish && (cur == CHW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res <= '0; code <= RW'(8); ael <= 1'b1; aeh <= 1'b1;
        afl <= 1'b0; afh <= 1'b0; lo <= 8'h00; hi <= 8'hFF;
      end else begin
        if (reg_we && !w_por && w_ch == CHW'(c)) begin
          case (w_sel)
            2'd0: begin code <= reg_wdata[RW-1:0]; ael <= reg_wdata[4]; aeh <= reg_wdata[5]; end
            2'd1: begin afl <= afl & reg_wdata[0]; afh <= afh & reg_wdata[1]; end
            2'd2: lo <= reg_wdata;
            default: hi <= reg_wdata;
          endcase
        end
        if (accept && req_mask[c]) begin
          if (pre == 2'b01) res <= '0;
          else if (pre == 2'b10) res <= '1;
        end
        if (hit) begin
          res <= aligned;
          afh <= top > (hi & tmask);
          afl <= top < (lo & tmask);
        end
      end
    end

    assign res_w[c]  = res;
    assign code_w[c] = code;
    assign lo_w[c]   = lo;
    assign hi_w[c]   = hi;
    assign ael_w[c]  = ael;
    assign aeh_w[c]  = aeh;
    assign afl_w[c]  = afl;
    assign afh_w[c]  = afh;
    assign results[c*DW +: DW] = res;
  end

  always_comb begin
    logic [CHW-1:0] rc;
    rc = reg_raddr[CHW+1:2];
    reg_rdata = 8'h00;
    if (reg_raddr[AW-1]) reg_rdata = {7'b0, por};
    else begin
      case (reg_raddr[1:0])
        2'd0: reg_rdata = {2'b0, aeh_w[rc], ael_w[rc], (4)'(code_w[rc])};
        2'd1: reg_rdata = {6'b0, afh_w[rc], afl_w[rc]};
        2'd2: reg_rdata = lo_w[rc];
        default: reg_rdata = hi_w[rc];
      endcase
    end
  end

  // R1
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R10
  last_done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && pend_rest == '0) |=> ready);

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (DW'(res_w[$past(cur)] << $past(nbits)) == '0));

  // R4
  preset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mask[0] && req_preset[1:0] == 2'b10) |=> (res_w[0] == '1));

  // R8
  por_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por |-> search_hit);

endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/100ps
module tb_adc_scan_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_mask = '0;
  logic [7:0] req_preset = '0;
  logic reg_we = 1'b0;
  logic [4:0] reg_waddr = '0;
  logic [7:0] reg_wdata = '0;
  logic [4:0] reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic conv_start;
  logic [1:0] conv_ch;
  logic [4:0] conv_bits;
  logic conv_done = 1'b0;
  logic [15:0] conv_raw = '0;
  logic [63:0] results;
  logic ready, search_hit;

  always #2.5 clk = ~clk;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
    .req_preset(req_preset), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_bits(conv_bits),
    .conv_done(conv_done), .conv_raw(conv_raw), .results(results),
    .ready(ready), .search_hit(search_hit));

  int total = 0, fails = 0;
  int m_res[4], m_code[4], m_lo[4], m_hi[4], raw_val[4];
  bit m_ael[4], m_aeh[4], m_afl[4], m_afh[4];
  bit m_por;
  int m_phase;
  int q[$];
  int lat_cnt = -1, lat_set = 1, cv_ch = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bits_of(int code);
    return (code == 0) ? 16 : code;
  endfunction

  function automatic bit model_search();
    bit s = m_por;
    for (int c = 0; c < 4; c++) s |= (m_afl[c] & m_ael[c]) | (m_afh[c] & m_aeh[c]);
    return s;
  endfunction

  task automatic step();
    if (rst_n) begin
      if (reg_we) begin
        if (reg_waddr[4]) m_por = reg_wdata[0];
        else begin
          int c = int'(reg_waddr[3:2]);
          case (reg_waddr[1:0])
            2'd0: begin m_code[c] = reg_wdata & 15; m_ael[c] = reg_wdata[4]; m_aeh[c] = reg_wdata[5]; end
            2'd1: begin m_afl[c] &= reg_wdata[0]; m_afh[c] &= reg_wdata[1]; end
            2'd2: m_lo[c] = reg_wdata;
            default: m_hi[c] = reg_wdata;
          endcase
        end
      end
      if (m_phase == 0) begin
        if (req_valid && req_mask != 0) begin
          for (int c = 0; c < 4; c++) if (req_mask[c]) begin
            int p = (req_preset >> (2*c)) & 3;
            if (p == 1) m_res[c] = 0;
            else if (p == 2) m_res[c] = 'hFFFF;
            q.push_back(c);
          end
          m_phase = 1;
        end
      end else if (m_phase == 1) m_phase = 2;
      else if (conv_done) begin
        int c = q.pop_front();
        int n = bits_of(m_code[c]);
        int a = (int'(conv_raw) << (16 - n)) & 'hFFFF;
        int tp = a >> 8;
        int tm = (n >= 8) ? 255 : ((255 << (8 - n)) & 255);
        m_res[c] = a;
        m_afh[c] = tp > (m_hi[c] & tm);
        m_afl[c] = tp < (m_lo[c] & tm);
        m_phase = (q.size() != 0) ? 1 : 0;
      end
    end
    @(posedge clk); #1;
    conv_done = 1'b0;
    if (lat_cnt > 0) lat_cnt--;
    if (lat_cnt == 0) begin conv_done = 1'b1; conv_raw = 16'(raw_val[cv_ch]); lat_cnt = -1; end
    check(conv_start == (m_phase == 1), "R1", "conv_start", conv_start, m_phase == 1);
    if (conv_start && q.size() != 0) begin
      check(int'(conv_ch) == q[0], "R1", "conv_ch order", conv_ch, q[0]);
      check(int'(conv_bits) == bits_of(m_code[q[0]]), "R2", "conv_bits", conv_bits, bits_of(m_code[q[0]]));
      cv_ch = int'(conv_ch);
      lat_cnt = lat_set;
    end
    check(ready == (m_phase == 0), "R10", "ready", ready, m_phase == 0);
    for (int c = 0; c < 4; c++)
      check(int'(results[16*c +: 16]) == m_res[c], "R3", $sformatf("result ch%0d", c), results[16*c +: 16], m_res[c]);
    check(search_hit == model_search(), "R8", "search_hit", search_hit, model_search());
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input int exp, input string req, input string what);
    reg_raddr = a; #1;
    check(int'(reg_rdata) == exp, req, what, reg_rdata, exp);
  endtask

  task automatic run_until_idle();
    for (int i = 0; i < 200 && !(m_phase == 0 && lat_cnt < 0 && !conv_done); i++) step();
  endtask

  task automatic convert(input logic [3:0] m, input logic [7:0] p, input int lat);
    req_valid = 1'b1; req_mask = m; req_preset = p; lat_set = lat;
    step();
    req_valid = 1'b0;
    run_until_idle();
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_res[c] = 0; m_code[c] = 8; m_lo[c] = 0; m_hi[c] = 'hFF;
      m_ael[c] = 1; m_aeh[c] = 1; m_afl[c] = 0; m_afh[c] = 0;
    end
    m_por = 1; m_phase = 0;
    raw_val[0] = 'hABC; raw_val[1] = 'h1234; raw_val[2] = 'h9; raw_val[3] = 'h7F;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    rd(5'h02, 'h00, "R9", "low threshold reset");
    rd(5'h03, 'hFF, "R9", "high threshold reset");
    rd(5'h00, 'h38, "R9", "control reset");
    rd(5'h10, 'h01, "R9", "power-on bit reset");
    check(results == '0, "R9", "results reset", results, 0);
    wr(5'h10, 8'h00);
    check(search_hit == 1'b0, "R8", "search after power-on clear", search_hit, 0);
    wr(5'h00, 8'h0C);
    wr(5'h04, 8'h30);
    wr(5'h08, 8'h24);
    wr(5'h0C, 8'h28);
    wr(5'h0A, 8'h95);
    wr(5'h0B, 8'h8F);
    wr(5'h0F, 8'h70);
    rd(5'h04, 'h30, "R11", "control readback");
    rd(5'h0B, 'h8F, "R11", "threshold readback");
    // R6: 4-bit result 0x9000 vs masked thresholds
    convert(4'b0100, 8'h00, 2);
    rd(5'h09, 'h02, "R6", "masked threshold flags");
    check(results[47:32] == 16'h9000, "R3", "4-bit alignment", results[47:32], 'h9000);
    // R4 presets, R1 order with a skipped channel
    req_valid = 1'b1; req_mask = 4'b1011; req_preset = 8'h26; lat_set = 3;
    step();
    req_valid = 1'b0;
    check(results[15:0] == 16'hFFFF, "R4", "preset ones", results[15:0], 'hFFFF);
    check(results[31:16] == 16'h0000, "R4", "preset zeros", results[31:16], 0);
    check(results[47:32] == 16'h9000, "R4", "unselected untouched", results[47:32], 'h9000);
    run_until_idle();
    check(results[15:0] == 16'hABC0, "R3", "12-bit alignment", results[15:0], 'hABC0);
    check(results[31:16] == 16'h1234, "R2", "16-bit from code 0", results[31:16], 'h1234);
    rd(5'h0D, 'h02, "R5", "high alarm ch3");
    // R7 automatic clear
    raw_val[3] = 'h20;
    convert(4'b1000, 8'h00, 1);
    rd(5'h0D, 'h00, "R7", "flag cleared by conversion");
    wr(5'h09, 8'h02);
    rd(5'h09, 'h02, "R7", "write of 1 keeps flag");
    wr(5'h09, 8'h00);
    rd(5'h09, 'h00, "R7", "write of 0 clears flag");
    check(search_hit == 1'b0, "R8", "search idle", search_hit, 0);
    // R5 low alarm on a 16-bit channel
    wr(5'h06, 8'h20);
    convert(4'b0010, 8'h00, 1);
    rd(5'h05, 'h01, "R5", "low alarm ch1");
    check(search_hit == 1'b1, "R8", "search from low alarm", search_hit, 1);
    // R10 zero mask, request while busy
    convert(4'b0000, 8'hFF, 1);
    check(ready == 1'b1, "R10", "zero mask stays ready", ready, 1);
    req_valid = 1'b1; req_mask = 4'b0001; req_preset = 8'h00; lat_set = 5;
    step();
    req_mask = 4'b1111; req_preset = 8'hAA;
    step();
    req_valid = 1'b0;
    run_until_idle();
    check(results[31:16] == 16'h1234, "R10", "busy request ignored", results[31:16], 'h1234);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule